// File: doc/BRIEF.md
# Crate Event Readout Sequencer

This block sequences the readout of one event from a crate of time digitizers. A common stop pulse captures a 16-bit event number and arms a wait for a separate buffer-ready strobe. The digitizers raise that strobe some microseconds after the stop. Once the strobe arrives, the block walks the digitizers in ascending index order. It pulls hit words through a one-request, one-response read port until each digitizer reports that it has no more data.

Every event leaves the block as a framed stream of 32-bit words with valid/ready flow control. The stream feeds a wide parallel link. The frame is a header that carries the captured event number, then the hit words, then a trailer that carries the hit count. If the strobe does not arrive within a parameter-set number of clock cycles, the block emits a single header word with an error bit set and goes back to waiting for a stop. Stops that arrive while an event is still in progress are counted and otherwise dropped.

Top module: `evr_seq`

## Requirements
- R1: After reset, `out_valid_o` and `rd_req_o` are low and `missed_cnt_o` is zero.
- R2: A stop pulse seen while idle captures `evn_i`. The first word of the resulting event has bits 31:16 equal to 0xEE00 and bits 15:0 equal to the captured number.
- R3: No read request is issued between the stop and the strobe. A strobe pulse while idle produces no request and no output word.
- R4: After the strobe, digitizers are read in index order 0 to N_DIGI-1. Each digitizer is read until a response has `rd_done_i` high. Each response with `rd_done_i` low is forwarded unchanged, in order, as one output word.
- R5: The last word of a normal event has bits 31:16 equal to 0xFF00 and bits 15:0 equal to the number of hit words forwarded. `out_last_o` is high on that word and on no earlier word of the event.
- R6: A digitizer that answers its first request with `rd_done_i` contributes no word. An event without hits is exactly a header and a trailer with count 0.
- R7: If no strobe arrives within TMO_CYCLES cycles of the stop, the event is one word with bits 31:16 equal to 0xEE01 and the event number below. That word has `out_last_o` high and no read request is made. The word appears between TMO_CYCLES and TMO_CYCLES+8 cycles after the stop.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` hold. No word is lost or duplicated under any ready pattern.
- R9: A stop seen while an event is in progress increments `missed_cnt_o` by one and leaves the event number of that event unchanged. The counter never decreases and changes only after a stop.
- R10: `rd_req_o` is a one-cycle pulse, at most one request is outstanding, and a request is issued only while the output register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Common stop pulse, one cycle |
| evn_i | input | 16 | Event number sampled at the stop |
| strobe_i | input | 1 | Buffer-ready pulse from the digitizers |
| rd_req_o | output | 1 | Read request pulse |
| rd_sel_o | output | SEL_W | Index of the digitizer being read |
| rd_valid_i | input | 1 | Read response valid |
| rd_done_i | input | 1 | Response carries no data; digitizer exhausted |
| rd_data_i | input | 32 | Hit word of the response |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | 32 | Output word |
| out_last_o | output | 1 | Final word of the event |
| missed_cnt_o | output | 16 | Count of stops dropped while busy |

## Verification
A stuck or skipped sequencer state shows at the ports within one event. It appears as a missing trailer, a hit count that disagrees with the words delivered, a digitizer index out of order, or a request while a word is still pending. A wrong timeout counter shifts the error header outside its window of a few cycles, which is observable about TMO_CYCLES cycles after the stop. A missed stop wrongly treated as a capture changes the header of the event in flight, visible on its first word.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam logic [15:0] HDR_TAG = 16'hEE00;
  localparam logic [15:0] TRL_TAG = 16'hFF00;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_HDR,
    S_REQ,
    S_RESP,
    S_TRL
  } seq_state_t;
endpackage

// File: rtl/evr_evn_latch.sv
module evr_evn_latch #(
  parameter int EVN_W = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic              idle_i,
  input  logic [EVN_W-1:0]  evn_i,
  output logic              start_o,
  output logic [EVN_W-1:0]  evn_o,
  output logic [MISS_W-1:0] missed_o
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o  <= 1'b0;
      evn_o    <= '0;
      missed_o <= '0;
    end else begin
      start_o <= 1'b0;
      if (stop_i && idle_i) begin
        evn_o   <= evn_i;
        start_o <= 1'b1;
      end else if (stop_i && missed_o != MISS_MAX) begin
        missed_o <= missed_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evr_strobe_timer.sv
module evr_strobe_timer #(
  parameter int TMO_CYCLES = 500,
  localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic strobe_i,
  output logic got_o,
  output logic tmo_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYCLES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      got_o    <= 1'b0;
      tmo_o    <= 1'b0;
    end else begin
      got_o <= 1'b0;
      tmo_o <= 1'b0;
      if (arm_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (strobe_i) begin
          active_q <= 1'b0;
          got_o    <= 1'b1;
        end else if (cnt_q == LIMIT) begin
          active_q <= 1'b0;
          tmo_o    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evr_out_stage.sv
module evr_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evr_seq.sv
module evr_seq
  import evr_pkg::*;
#(
  parameter int N_DIGI     = 5,
  parameter int TMO_CYCLES = 500,
  parameter int EVN_W      = 16,
  parameter int WORD_W     = 32,
  parameter int MISS_W     = 16,
  localparam int SEL_W     = (N_DIGI > 1) ? $clog2(N_DIGI) : 1,
  localparam int HCNT_W    = WORD_W - 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic [EVN_W-1:0]  evn_i,
  input  logic              strobe_i,
  output logic              rd_req_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic              rd_valid_i,
  input  logic              rd_done_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic [MISS_W-1:0] missed_cnt_o
);
  localparam logic [SEL_W-1:0] LAST_DIG = SEL_W'(N_DIGI - 1);

  seq_state_t        state_q;
  logic [SEL_W-1:0]  dig_q;
  logic [HCNT_W-1:0] hits_q;
  logic              err_q;
  logic              rd_req_q;

  logic              start;
  logic [EVN_W-1:0]  evn_q;
  logic              got, tmo;
  logic              push, plast, free;
  logic [WORD_W-1:0] pdata;
  logic              idle;

  assign idle = (state_q == S_IDLE) && !start;

  evr_evn_latch #(.EVN_W(EVN_W), .MISS_W(MISS_W)) u_latch (
    .clk(clk), .rst(rst), .stop_i(stop_i), .idle_i(idle), .evn_i(evn_i),
    .start_o(start), .evn_o(evn_q), .missed_o(missed_cnt_o)
  );

  evr_strobe_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm_i(start), .strobe_i(strobe_i),
    .got_o(got), .tmo_o(tmo)
  );

  evr_out_stage #(.W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .push_i(push), .data_i(pdata), .last_i(plast),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o),
    .last_o(out_last_o), .free_o(free)
  );

  // Output word selection per state
  always_comb begin
    push  = 1'b0;
    plast = 1'b0;
    pdata = '0;
    case (state_q)
      S_HDR: begin
        push  = free;
        plast = err_q;
        pdata = WORD_W'({HDR_TAG | {15'd0, err_q}, 16'(evn_q)});
      end
      S_RESP: begin
        push  = rd_valid_i && !rd_done_i;
        pdata = rd_data_i;
      end
      S_TRL: begin
        push  = free;
        plast = 1'b1;
        pdata = WORD_W'({TRL_TAG, 16'(hits_q)});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      dig_q    <= '0;
      hits_q   <= '0;
      err_q    <= 1'b0;
      rd_req_q <= 1'b0;
    end else begin
      rd_req_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) state_q <= S_WAIT;
        S_WAIT: begin
          if (got) begin
            err_q   <= 1'b0;
            state_q <= S_HDR;
          end else if (tmo) begin
            err_q   <= 1'b1;
            state_q <= S_HDR;
          end
        end
        S_HDR: begin
          if (free) begin
            dig_q   <= '0;
            hits_q  <= '0;
            state_q <= err_q ? S_IDLE : S_REQ;
          end
        end
        S_REQ: begin
          if (!out_valid_o) begin
            rd_req_q <= 1'b1;
            state_q  <= S_RESP;
          end
        end
        S_RESP: begin
          if (rd_valid_i) begin
            if (rd_done_i) begin
              if (dig_q == LAST_DIG) begin
                state_q <= S_TRL;
              end else begin
                dig_q   <= dig_q + 1'b1;
                state_q <= S_REQ;
              end
            end else begin
              hits_q  <= hits_q + 1'b1;
              state_q <= S_REQ;
            end
          end
        end
        S_TRL: if (free) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o = rd_req_q;
  assign rd_sel_o = dig_q;
endmodule

// File: rtl/evr_seq_chk.sv
module evr_seq_chk #(
  parameter int WORD_W = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_i,
  input logic              rd_req_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_last_o,
  input logic [MISS_W-1:0] missed_cnt_o
);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);

  p_req_empty_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> !out_valid_o);

  p_missed_mono_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (missed_cnt_o >= $past(missed_cnt_o)));

  p_missed_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (missed_cnt_o != $past(missed_cnt_o)) |-> $past(stop_i));
endmodule

bind evr_seq evr_seq_chk #(.WORD_W(WORD_W), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst(rst), .stop_i(stop_i), .rd_req_o(rd_req_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_last_o(out_last_o),
  .missed_cnt_o(missed_cnt_o)
);

// File: tb/evr_seq_tb.sv
module evr_seq_tb;
  localparam int N = 5;
  localparam int TMO = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop_i = 1'b0;
  logic [15:0] evn_i = '0;
  logic        strobe_i = 1'b0;
  logic        rd_req_o;
  logic [2:0]  rd_sel_o;
  logic        rd_valid_i = 1'b0;
  logic        rd_done_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        out_last_o;
  logic [15:0] missed_cnt_o;

  always #5 clk = ~clk;

  evr_seq #(.N_DIGI(N), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst(rst), .stop_i(stop_i), .evn_i(evn_i), .strobe_i(strobe_i),
    .rd_req_o(rd_req_o), .rd_sel_o(rd_sel_o), .rd_valid_i(rd_valid_i),
    .rd_done_i(rd_done_i), .rd_data_i(rd_data_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .missed_cnt_o(missed_cnt_o)
  );

  int total = 0;
  int bad = 0;
  int nh[N];
  int ridx[N];
  int req_seen = 0;
  int bad_order = 0;
  int last_sel = 0;
  logic [31:0] cap[64];
  logic        capl[64];
  int ncap = 0;
  int stall_chk = 0;
  int stall_bad = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic        rmode = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic [31:0] expw[64];
  int ne = 0;

  function automatic logic [31:0] hv(int d, int k);
    return {8'hA0, 4'(d), 4'h0, 16'(k * 3 + 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Downstream ready pattern
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready_i <= rmode ? lfsr[0] : 1'b1;
  end

  // Digitizer read model
  always @(negedge clk) begin
    rd_valid_i <= 1'b0;
    if (rd_req_o) begin
      int d;
      d = int'(rd_sel_o);
      req_seen <= req_seen + 1;
      if (d < last_sel) bad_order <= bad_order + 1;
      last_sel <= d;
      rd_valid_i <= 1'b1;
      if (d < N && ridx[d] < nh[d]) begin
        rd_done_i <= 1'b0;
        rd_data_i <= hv(d, ridx[d]);
        ridx[d] <= ridx[d] + 1;
      end else begin
        rd_done_i <= 1'b1;
        rd_data_i <= 32'hDEAD_DEAD;
      end
    end
  end

  // Output collector and stall monitor
  always @(negedge clk) begin
    if (prev_stall) begin
      stall_chk <= stall_chk + 1;
      if (!(out_valid_o && out_data_o == prev_data)) stall_bad <= stall_bad + 1;
    end
    prev_stall <= out_valid_o && !out_ready_i;
    prev_data  <= out_data_o;
    if (out_valid_o && out_ready_i && ncap < 64) begin
      cap[ncap]  <= out_data_o;
      capl[ncap] <= out_last_o;
      ncap <= ncap + 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_run();
    @(negedge clk);
    ncap = 0;
    req_seen = 0;
    last_sel = 0;
    bad_order = 0;
    for (int d = 0; d < N; d++) ridx[d] = 0;
  endtask

  task automatic pulse_stop(logic [15:0] v);
    @(negedge clk);
    stop_i = 1'b1;
    evn_i = v;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic pulse_strobe();
    @(negedge clk);
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim; i++) begin
      tick(1);
      if (ncap > 0 && capl[ncap-1]) break;
    end
    tick(2);
  endtask

  task automatic build_exp(logic [15:0] v);
    int h;
    h = 0;
    ne = 0;
    expw[ne] = {16'hEE00, v};
    ne++;
    for (int d = 0; d < N; d++)
      for (int k = 0; k < nh[d]; k++) begin
        expw[ne] = hv(d, k);
        ne++;
        h++;
      end
    expw[ne] = {16'hFF00, 16'(h)};
    ne++;
  endtask

  task automatic compare_event(string req);
    bit lastok;
    chk(ncap == ne, {req, " word count"}, 32'(ncap), 32'(ne));
    if (ncap == ne) begin
      for (int i = 0; i < ne; i++)
        chk(cap[i] == expw[i], req, cap[i], expw[i]);
      lastok = 1'b1;
      for (int i = 0; i < ne - 1; i++) if (capl[i]) lastok = 1'b0;
      if (!capl[ne-1]) lastok = 1'b0;
      chk(lastok, "R5 out_last placement", 32'(lastok), 32'd1);
    end
    chk(bad_order == 0, "R4 digitizer order", 32'(bad_order), 32'd0);
  endtask

  task automatic t_reset();
    tick(1);
    chk(!out_valid_o && !rd_req_o, "R1 outputs idle after reset",
        {30'd0, out_valid_o, rd_req_o}, 32'd0);
    chk(missed_cnt_o == 16'd0, "R1 missed count zero", 32'(missed_cnt_o), 32'd0);
  endtask

  task automatic t_basic();
    nh[0] = 2; nh[1] = 0; nh[2] = 3; nh[3] = 1; nh[4] = 0;
    clear_run();
    pulse_stop(16'h1234);
    tick(30);
    chk(req_seen == 0 && ncap == 0, "R3 nothing before strobe", 32'(req_seen + ncap), 32'd0);
    pulse_strobe();
    wait_done(300);
    build_exp(16'h1234);
    compare_event("R2 R4 R5 basic event");
  endtask

  task automatic t_empty();
    for (int d = 0; d < N; d++) nh[d] = 0;
    clear_run();
    pulse_stop(16'h00F0);
    tick(5);
    pulse_strobe();
    wait_done(200);
    build_exp(16'h00F0);
    compare_event("R6 empty event");
    chk(req_seen == N, "R6 one request per digitizer", 32'(req_seen), 32'(N));
  endtask

  task automatic t_idle_strobe();
    clear_run();
    pulse_strobe();
    tick(40);
    chk(ncap == 0, "R3 idle strobe gives no word", 32'(ncap), 32'd0);
    chk(req_seen == 0, "R3 idle strobe gives no request", 32'(req_seen), 32'd0);
  endtask

  task automatic t_timeout();
    int cyc;
    clear_run();
    pulse_stop(16'hBEEF);
    cyc = 1;
    while (cyc < TMO + 40 && !out_valid_o) begin
      tick(1);
      cyc++;
    end
    wait_done(20);
    chk(cyc >= TMO && cyc <= TMO + 8, "R7 timeout delay", 32'(cyc), 32'(TMO));
    chk(ncap == 1, "R7 single word", 32'(ncap), 32'd1);
    chk(cap[0] == 32'hEE01_BEEF && capl[0], "R7 error header", cap[0], 32'hEE01_BEEF);
    chk(req_seen == 0, "R7 no reads", 32'(req_seen), 32'd0);
  endtask

  task automatic t_missed();
    for (int d = 0; d < N; d++) nh[d] = 0;
    nh[1] = 1;
    clear_run();
    pulse_stop(16'h0101);
    tick(10);
    pulse_stop(16'h0202);
    tick(5);
    pulse_stop(16'h0303);
    pulse_strobe();
    wait_done(200);
    chk(missed_cnt_o == 16'd2, "R9 missed count", 32'(missed_cnt_o), 32'd2);
    build_exp(16'h0101);
    compare_event("R9 event number kept");
    for (int d = 0; d < N; d++) nh[d] = 0;
    clear_run();
    pulse_stop(16'h0404);
    tick(3);
    pulse_strobe();
    wait_done(200);
    build_exp(16'h0404);
    compare_event("R2 capture after missed stops");
    chk(missed_cnt_o == 16'd2, "R9 count unchanged by idle stop", 32'(missed_cnt_o), 32'd2);
  endtask

  task automatic t_stall();
    nh[0] = 4; nh[1] = 2; nh[2] = 0; nh[3] = 5; nh[4] = 3;
    clear_run();
    stall_chk = 0;
    stall_bad = 0;
    rmode = 1'b1;
    pulse_stop(16'h7A7A);
    tick(8);
    pulse_strobe();
    wait_done(1500);
    rmode = 1'b0;
    tick(4);
    build_exp(16'h7A7A);
    compare_event("R8 event under backpressure");
    chk(stall_chk > 0 && stall_bad == 0, "R8 hold during stall",
        32'(stall_bad), 32'd0);
  endtask

  initial begin
    for (int d = 0; d < N; d++) begin
      nh[d] = 0;
      ridx[d] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_empty();
    t_idle_strobe();
    t_timeout();
    t_missed();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule